// File: doc/BRIEF.md
# Privileged call dispatch unit

This block turns a trap or exception index into a dispatch decision for the handler layer of a processor. A small set of fixed exception kinds each get their own vector. Two 8192-wide windows of the index space carry call functions: the lower window yields function codes 0x00 to 0x7F, which are privileged, and the upper window yields codes 0x80 to 0xFF, which any mode may issue. A privileged code is refused when the current-mode field of the processor status is nonzero. Any index outside the known ranges is flagged as an error.

The block also performs the handler-swap operation itself. It holds the active handler-set selection and the handler base register. Function 0x0A requests a swap, with the identifier taken from the argument register value. Each accepted dispatch also writes back the saved exception address with bit 0 cleared. All outputs are registered and appear one clock after the request strobe.

Top module: `call_dispatch`

## Requirements
- R1: An index below 12 is a fixed exception kind. One cycle after the strobe, disp_o=1, call_o=0, priv_o=0 and vec_o equals the index.
- R2: An index in [0x2000, 0x4000) is a privileged call. vec_o = (index-0x2000)>>6 (0x00..0x7F), with call_o=1 and priv_o=1.
- R3: An index in [0x4000, 0x6000) is an unprivileged call. vec_o = ((index-0x4000)>>6)+0x80. It is accepted for any status value and priv_o=0.
- R4: A privileged call is accepted only when ps_i[4:3] is zero. Otherwise priv_viol_o=1, disp_o=0, and no swap or address write takes place.
- R5: Every other index (12..0x1FFF and 0x6000 and above) gives idx_err_o=1 with no dispatch, no violation and no state change.
- R6: Each accepted dispatch pulses ea_we_o, and ea_o carries saved_addr_i with bit 0 cleared.
- R7: An accepted call 0x0A with an argument of 0, 1 or 2 sets hset_o to that value, sets hbase_o to all ones and pulses hreset_o.
- R8: A swap argument from 3 to 255 pulses res_we_o with res_o=1. hset_o and hbase_o stay unchanged.
- R9: A swap argument above 255 sets hset_o=3 (no built-in set), loads hbase_o with the argument and pulses pc_we_o with pc_o equal to the argument.
- R10: After reset, hset_o=0, hbase_o is all ones and every strobe output is low.
- R11: Only function 0x0A swaps. Other call codes, including 0x8A in the upper window, leave hset_o and hbase_o unchanged whatever the argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception index strobe |
| exc_idx_i | input | IDX_W | Exception index |
| ps_i | input | PS_W | Processor status; bits above bit 2 hold the mode |
| arg_i | input | DATA_W | Argument register value (swap identifier) |
| saved_addr_i | input | DATA_W | Current saved exception address |
| disp_o | output | 1 | Dispatch accepted |
| call_o | output | 1 | Dispatch is a call function |
| priv_o | output | 1 | Dispatched call is privileged |
| vec_o | output | 8 | Fixed-kind number or call function code |
| priv_viol_o | output | 1 | Privileged call refused |
| idx_err_o | output | 1 | Index outside every range |
| hset_o | output | 2 | Active handler set, 3 = none |
| hbase_o | output | DATA_W | Handler base register |
| hreset_o | output | 1 | Handler-set reset pulse |
| res_we_o | output | 1 | Result register write |
| res_o | output | DATA_W | Result register value |
| pc_we_o | output | 1 | Program counter redirect |
| pc_o | output | DATA_W | Redirect target |
| ea_we_o | output | 1 | Saved exception address write |
| ea_o | output | DATA_W | Saved address with bit 0 cleared |

## Verification
A wrong handler selection or base value stays in place and shows on hset_o and hbase_o from the cycle after the faulty swap. Every later comparison then differs until another swap repairs it, so the bench checks both registers on every cycle and not only after a swap. A mis-decoded range or shift shows on vec_o, call_o and priv_o one cycle after the strobe. A wrong mode check shows as a swapped priv_viol_o/disp_o pair in that same cycle. Swaps with an unknown identifier must leave the registers untouched, and the first compare after such a swap detects any disturbance.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [1:0] {
    CLS_FIXED = 2'd0,
    CLS_LO    = 2'd1,
    CLS_HI    = 2'd2,
    CLS_BAD   = 2'd3
  } idx_cls_e;

  localparam logic [7:0] SWAP_FUNC = 8'h0A;
  localparam logic [1:0] HSET_NONE = 2'd3;
endpackage

// File: rtl/call_idx_decode.sv
module call_idx_decode
  import dispatch_pkg::*;
#(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned NUM_FIXED = 12,
  parameter int unsigned LO_BASE   = 'h2000,
  parameter int unsigned HI_BASE   = 'h4000,
  parameter int unsigned FUNC_SH   = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output idx_cls_e         cls_o,
  output logic [7:0]       vec_o
);
  localparam int unsigned SPAN = 128 << FUNC_SH;

  logic [IDX_W-1:0] lo_off, hi_off;
  assign lo_off = idx_i - IDX_W'(LO_BASE);
  assign hi_off = idx_i - IDX_W'(HI_BASE);

  always_comb begin
    cls_o = CLS_BAD;
    vec_o = '0;
    if (idx_i < IDX_W'(NUM_FIXED)) begin
      cls_o = CLS_FIXED;
      vec_o = 8'(idx_i);
    end else if (idx_i >= IDX_W'(LO_BASE) && lo_off < IDX_W'(SPAN)) begin
      cls_o = CLS_LO;
      vec_o = {1'b0, lo_off[FUNC_SH +: 7]};
    end else if (idx_i >= IDX_W'(HI_BASE) && hi_off < IDX_W'(SPAN)) begin
      cls_o = CLS_HI;
      vec_o = {1'b1, hi_off[FUNC_SH +: 7]};
    end
  end
endmodule

// File: rtl/handler_swap.sv
module handler_swap
  import dispatch_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic [DATA_W-1:0] id_i,
  output logic [1:0]        hset_o,
  output logic [DATA_W-1:0] hbase_o,
  output logic              hreset_o,
  output logic              res_we_o,
  output logic [DATA_W-1:0] res_o,
  output logic              pc_we_o,
  output logic [DATA_W-1:0] pc_o
);
  // reset state equals a completed swap to set 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hset_o   <= 2'd0;
      hbase_o  <= '1;
      hreset_o <= 1'b0;
      res_we_o <= 1'b0;
      res_o    <= '0;
      pc_we_o  <= 1'b0;
      pc_o     <= '0;
    end else begin
      hreset_o <= 1'b0;
      res_we_o <= 1'b0;
      pc_we_o  <= 1'b0;
      if (swap_i) begin
        if (id_i < DATA_W'(3)) begin
          hset_o   <= id_i[1:0];
          hbase_o  <= '1;
          hreset_o <= 1'b1;
        end else if (id_i < DATA_W'(256)) begin
          res_we_o <= 1'b1;
          res_o    <= DATA_W'(1);
        end else begin
          hset_o  <= HSET_NONE;
          hbase_o <= id_i;
          pc_we_o <= 1'b1;
          pc_o    <= id_i;
        end
      end
    end
  end

  assert_builtin_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreset_o |-> (hbase_o == '1) && (hset_o != HSET_NONE));

  assert_unknown_id_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> $stable(hbase_o) && $stable(hset_o) && (res_o == DATA_W'(1)));

  assert_entry_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (pc_o == hbase_o) && (hset_o == HSET_NONE));

  assert_one_outcome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hreset_o, res_we_o, pc_we_o}) <= 1);
endmodule

// File: rtl/call_dispatch.sv
module call_dispatch
  import dispatch_pkg::*;
#(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned PS_W      = 5,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_FIXED = 12,
  parameter int unsigned LO_BASE   = 'h2000,
  parameter int unsigned HI_BASE   = 'h4000,
  parameter int unsigned FUNC_SH   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [IDX_W-1:0]  exc_idx_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [DATA_W-1:0] arg_i,
  input  logic [DATA_W-1:0] saved_addr_i,
  output logic              disp_o,
  output logic              call_o,
  output logic              priv_o,
  output logic [7:0]        vec_o,
  output logic              priv_viol_o,
  output logic              idx_err_o,
  output logic [1:0]        hset_o,
  output logic [DATA_W-1:0] hbase_o,
  output logic              hreset_o,
  output logic              res_we_o,
  output logic [DATA_W-1:0] res_o,
  output logic              pc_we_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              ea_we_o,
  output logic [DATA_W-1:0] ea_o
);
  localparam int unsigned MODE_LSB = 3;

  idx_cls_e   cls;
  logic [7:0] vec;
  logic       is_priv, mode_ok, accept, swap;

  call_idx_decode #(
    .IDX_W(IDX_W), .NUM_FIXED(NUM_FIXED), .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE), .FUNC_SH(FUNC_SH)
  ) u_dec (
    .idx_i(exc_idx_i), .cls_o(cls), .vec_o(vec)
  );

  assign is_priv = (cls == CLS_LO);
  assign mode_ok = (ps_i[PS_W-1:MODE_LSB] == '0);
  assign accept  = exc_valid_i && (cls != CLS_BAD) && (!is_priv || mode_ok);
  assign swap    = accept && is_priv && (vec == SWAP_FUNC);

  handler_swap #(.DATA_W(DATA_W)) u_swap (
    .clk_i(clk_i), .rst_ni(rst_ni), .swap_i(swap), .id_i(arg_i),
    .hset_o(hset_o), .hbase_o(hbase_o), .hreset_o(hreset_o),
    .res_we_o(res_we_o), .res_o(res_o), .pc_we_o(pc_we_o), .pc_o(pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_o      <= 1'b0;
      call_o      <= 1'b0;
      priv_o      <= 1'b0;
      vec_o       <= '0;
      priv_viol_o <= 1'b0;
      idx_err_o   <= 1'b0;
      ea_we_o     <= 1'b0;
      ea_o        <= '0;
    end else begin
      disp_o      <= accept;
      call_o      <= accept && (cls != CLS_FIXED);
      priv_o      <= accept && is_priv;
      vec_o       <= accept ? vec : 8'd0;
      priv_viol_o <= exc_valid_i && is_priv && !mode_ok;
      idx_err_o   <= exc_valid_i && (cls == CLS_BAD);
      ea_we_o     <= accept;
      if (accept) ea_o <= saved_addr_i & ~DATA_W'(1);
    end
  end

  assert_viol_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |-> !disp_o && !ea_we_o && !hreset_o && !pc_we_o && !res_we_o);

  assert_err_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_err_o |-> !disp_o && !priv_viol_o && $stable(hbase_o) && $stable(hset_o));

  assert_ea_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_we_o |-> disp_o && !ea_o[0]);

  assert_disp_needs_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_o || priv_viol_o || idx_err_o) |-> $past(exc_valid_i));

  assert_priv_code_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o |-> call_o && !vec_o[7]);

  assert_swap_only_priv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreset_o || pc_we_o || res_we_o) |-> priv_o && (vec_o == SWAP_FUNC));
endmodule

// File: tb/call_dispatch_test.sv
module call_dispatch_test;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] idx = '0;
  logic [4:0]  ps = '0;
  logic [63:0] arg = '0;
  logic [63:0] saved = '0;

  logic        disp, call, priv, viol, err, hrst, res_we, pc_we, ea_we;
  logic [7:0]  vec;
  logic [1:0]  hset;
  logic [63:0] hbase, res, pc, ea;

  always #2 clk = ~clk;

  call_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(valid), .exc_idx_i(idx),
    .ps_i(ps), .arg_i(arg), .saved_addr_i(saved),
    .disp_o(disp), .call_o(call), .priv_o(priv), .vec_o(vec),
    .priv_viol_o(viol), .idx_err_o(err), .hset_o(hset), .hbase_o(hbase),
    .hreset_o(hrst), .res_we_o(res_we), .res_o(res), .pc_we_o(pc_we),
    .pc_o(pc), .ea_we_o(ea_we), .ea_o(ea)
  );

  typedef struct packed {
    logic        disp, call, priv, viol, err, hrst, res_we, pc_we, ea_we;
    logic [7:0]  vec;
    logic [1:0]  hset;
    logic [63:0] hbase, res, pc, ea;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    tests = 0;
  int    fails = 0;
  bit    done = 0;
  logic [1:0]  m_hset = 2'd0;
  logic [63:0] m_hbase = ONES;

  function automatic obs_t masked(obs_t o);
    obs_t r = o;
    if (!r.res_we) r.res = '0;
    if (!r.pc_we)  r.pc = '0;
    if (!r.ea_we)  r.ea = '0;
    return r;
  endfunction

  function automatic obs_t actual();
    obs_t a;
    a.disp = disp; a.call = call; a.priv = priv; a.viol = viol; a.err = err;
    a.hrst = hrst; a.res_we = res_we; a.pc_we = pc_we; a.ea_we = ea_we;
    a.vec = vec; a.hset = hset; a.hbase = hbase; a.res = res; a.pc = pc; a.ea = ea;
    return masked(a);
  endfunction

  function automatic obs_t idle_exp();
    obs_t e = '0;
    e.hset = m_hset;
    e.hbase = m_hbase;
    return e;
  endfunction

  // driver: applies one request and pushes the expected outcome
  task automatic send(input logic [15:0] i, input logic [4:0] s,
                      input logic [63:0] a, input logic [63:0] sv, input string tag);
    obs_t e = '0;
    bit lo, hi, fx, ok;
    logic [15:0] off;
    @(negedge clk);
    valid = 1'b1; idx = i; ps = s; arg = a; saved = sv;
    fx = (i < 16'd12);
    lo = (i >= 16'h2000) && (i < 16'h4000);
    hi = (i >= 16'h4000) && (i < 16'h6000);
    ok = (fx || lo || hi) && !(lo && s[4:3] != 2'b00);
    e.err  = !(fx || lo || hi);
    e.viol = lo && (s[4:3] != 2'b00);
    if (ok) begin
      e.disp = 1'b1; e.ea_we = 1'b1; e.ea = sv & ~64'd1;
      if (fx) e.vec = i[7:0];
      else begin
        e.call = 1'b1;
        off = lo ? i - 16'h2000 : i - 16'h4000;
        e.vec = {hi, off[12:6]};
        e.priv = lo;
      end
      if (lo && e.vec == 8'h0A) begin
        if (a < 64'd3) begin
          m_hset = a[1:0]; m_hbase = ONES; e.hrst = 1'b1;
        end else if (a < 64'd256) begin
          e.res_we = 1'b1; e.res = 64'd1;
        end else begin
          m_hset = 2'd3; m_hbase = a; e.pc_we = 1'b1; e.pc = a;
        end
      end
    end
    e.hset = m_hset;
    e.hbase = m_hbase;
    exp_q.push_back(masked(e));
    tag_q.push_back(tag);
  endtask

  task automatic pause();
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor: compares one cycle after each edge's capture
  always @(posedge clk) begin
    if (rst_n && !done) begin
      obs_t e, a;
      string t;
      #1;
      a = actual();
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = idle_exp();
        t = "R10 idle";
      end
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (hset !== 2'd0 || hbase !== ONES || disp || hrst || res_we || pc_we || ea_we || viol || err) begin
      fails++;
      $display("FAIL R10 reset actual=%h/%h expected=0/%h", hset, hbase, ONES);
    end
    rst_n = 1'b1;
    pause();
    // R1 fixed kinds
    send(16'd0,  5'd0,  64'd0, 64'h1001, "R1 kind0");
    send(16'd5,  5'h1F, 64'd0, 64'h2002, "R1 kind5");
    send(16'd11, 5'd0,  64'd0, 64'h3003, "R1 kind11");
    // R5 out of range
    send(16'd12,   5'd0, 64'd1, 64'h5, "R5 after fixed");
    send(16'h1FFF, 5'd0, 64'd1, 64'h5, "R5 below low");
    send(16'h6000, 5'd0, 64'd1, 64'h5, "R5 above high");
    send(16'hFFFF, 5'd0, 64'd1, 64'h5, "R5 top");
    // R2 privileged window, low status bits do not count as mode
    send(16'h2000 + 16'd3*64 + 16'd17, 5'b00111, 64'd0, 64'h7, "R2 func3");
    send(16'h3FFF, 5'd0, 64'd0, 64'hABCD, "R2 func7F");
    // R3 unprivileged window in a nonzero mode
    send(16'h4000, 5'b11000, 64'd0, 64'h10, "R3 func80");
    send(16'h4000 + 16'h2A*64 + 16'd63, 5'b01000, 64'd0, 64'h11, "R3 funcAA");
    // R4 privileged refused
    send(16'h2000 + 16'd3*64, 5'b01000, 64'd0, 64'h13, "R4 func3 mode1");
    send(16'h2000 + 16'd10*64, 5'b10000, 64'd2, 64'h13, "R4 swap refused");
    pause();
    // R7 / R8 / R9 swaps; R6 odd saved address
    send(16'h2000 + 16'd10*64, 5'd0, 64'd1, 64'hFFFF_0000_0000_1235, "R7 swap1 R6");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd300, 64'h1, "R9 swap300");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd200, 64'h3, "R8 swap200");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd255, 64'h3, "R8 swap255");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd2, 64'h2, "R7 swap2");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd3, 64'h2, "R8 swap3");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd256, 64'h2, "R9 swap256");
    send(16'h2000 + 16'd10*64 + 16'd63, 5'd0, 64'hDEAD_BEEF_0000_0000, 64'h9, "R9 swap big");
    // R11 neighbours of the swap code
    send(16'h2000 + 16'd11*64, 5'd0, 64'd0, 64'h4, "R11 func0B");
    send(16'h2000 + 16'd9*64 + 16'd63, 5'd0, 64'd1, 64'h4, "R11 func09");
    send(16'h4000 + 16'd10*64, 5'd0, 64'd0, 64'h4, "R11 func8A");
    send(16'd10, 5'd0, 64'd1, 64'h4, "R11 kind10");
    send(16'h2000 + 16'd10*64, 5'd0, 64'd0, 64'h6, "R7 swap0");
    pause();
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule